// File: doc/BRIEF.md
# Prioritized Multiway Branch Resolver

This block settles the control flow of one wide instruction word that may carry several conditional branch operations side by side. Compare-equal operations in the word do not set a shared condition flag. Each one writes a single result bit into a small bank of one-bit condition registers. A bit written this way stays there, so a later branch can test it.

Each branch slot carries a valid bit, a selector that names one condition register, and a target address. A slot is taken when it is valid and the register it names holds 1. When several slots are taken in the same word, the slot with the lowest index wins and its target becomes the next program counter. When no slot is taken, the program counter advances by one word. Branches read the condition registers as they stood before the current clock edge. Compares issued in the same word update the registers at that edge. The next PC, the winning slot index and a taken flag are registered and appear one cycle after the word is presented.

Top module: `multiway_branch_resolver`

## Requirements
- R1: A compare lane `c` with `cmp_en[c]=1` writes 1 into condition register `cmp_dst[c]` at the clock edge when `cmp_a[c]==cmp_b[c]`, and writes 0 otherwise.
- R2: A condition register keeps its value in every cycle in which no enabled compare lane names it. This lets a result written in one word be tested by a branch in a later word.
- R3: When two enabled compare lanes name the same register in one cycle, the lane with the higher index sets the stored value.
- R4: A branch slot `s` counts as taken when `br_valid[s]=1` and condition register `br_sel[s]` holds 1, as it stood before the current edge. A compare issued in the same cycle does not affect the branches in that cycle.
- R5: When several slots are taken, the lowest-numbered one wins. One cycle later `taken=1`, `win_slot` equals that slot's index, and `next_pc` equals `br_target` of that slot.
- R6: A slot with `br_valid[s]=0` never wins, even when the register it selects holds 1.
- R7: When no slot is taken, one cycle later `taken=0`, `win_slot=0`, and `next_pc` equals `cur_pc+1`, wrapping modulo 2^PC_W.
- R8: Synchronous reset clears all condition registers, `next_pc`, `win_slot` and `taken` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_en | input | NCMP | Enable per compare lane |
| cmp_a | input | NCMP x DATA_W | First operand per compare lane |
| cmp_b | input | NCMP x DATA_W | Second operand per compare lane |
| cmp_dst | input | NCMP x log2(NFLAG) | Destination condition register per compare lane |
| br_valid | input | NSLOT | Valid bit per branch slot |
| br_sel | input | NSLOT x log2(NFLAG) | Condition register tested by each slot |
| br_target | input | NSLOT x PC_W | Branch target per slot |
| cur_pc | input | PC_W | Address of the current instruction word |
| next_pc | output | PC_W | Registered next program counter |
| win_slot | output | log2(NSLOT) | Registered index of the winning slot, 0 when none |
| taken | output | 1 | Registered flag, 1 when some slot was taken |

## Verification
A corrupted condition register stays hidden until a branch selects it. It then shows up one cycle after that branch word as a wrong `taken`, a wrong `win_slot` or a fall-through `next_pc` where a jump was expected. For this reason the bench loads every one of the 256 register patterns through compares and then reads each pattern back through branch slots. A broken priority order shows on `win_slot` and `next_pc` in the cycle right after the first word in which two slots are taken together.

// File: rtl/mwbr_pkg.sv
package mwbr_pkg;
  typedef enum logic {
    FLOW_STEP = 1'b0,
    FLOW_JUMP = 1'b1
  } flow_e;

  localparam int unsigned PC_STEP_DEF = 1;
endpackage

// File: rtl/mwbr_cmp_unit.sv
module mwbr_cmp_unit #(
  parameter int unsigned NCMP   = 2,
  parameter int unsigned DATA_W = 8
) (
  input  logic [NCMP-1:0][DATA_W-1:0] op_a,
  input  logic [NCMP-1:0][DATA_W-1:0] op_b,
  output logic [NCMP-1:0]             equal
);
  for (genvar c = 0; c < NCMP; c++) begin : g_lane
    assign equal[c] = (op_a[c] == op_b[c]);
  end
endmodule

// File: rtl/mwbr_flag_bank.sv
module mwbr_flag_bank #(
  parameter int unsigned NCMP  = 2,
  parameter int unsigned NFLAG = 8,
  localparam int unsigned FSEL_W = $clog2(NFLAG)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NCMP-1:0]              wr_en,
  input  logic [NCMP-1:0][FSEL_W-1:0]  wr_dst,
  input  logic [NCMP-1:0]              wr_val,
  output logic [NFLAG-1:0]             flags
);
  for (genvar b = 0; b < NFLAG; b++) begin : g_flag
    logic hit;
    logic nval;
    always_comb begin
      hit  = 1'b0;
      nval = 1'b0;
      for (int c = 0; c < NCMP; c++) begin
        if (wr_en[c] && (wr_dst[c] == FSEL_W'(b))) begin
          hit  = 1'b1;
          nval = wr_val[c];
        end
      end
    end
    always_ff @(posedge clk) begin
      if (rst)      flags[b] <= 1'b0;
      else if (hit) flags[b] <= nval;
    end
  end

  // R1 R3
  last_lane_write_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en[NCMP-1] |=> flags[$past(wr_dst[NCMP-1])] == $past(wr_val[NCMP-1]));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && wr_en == '0) |=> $stable(flags));
endmodule

// File: rtl/mwbr_prio_pick.sv
module mwbr_prio_pick #(
  parameter int unsigned NSLOT = 4,
  parameter int unsigned NFLAG = 8,
  localparam int unsigned FSEL_W = $clog2(NFLAG),
  localparam int unsigned IDX_W  = $clog2(NSLOT)
) (
  input  logic [NFLAG-1:0]              flags,
  input  logic [NSLOT-1:0]              valid,
  input  logic [NSLOT-1:0][FSEL_W-1:0]  sel,
  output logic                          any,
  output logic [IDX_W-1:0]              idx
);
  logic [NSLOT-1:0] hit;

  for (genvar s = 0; s < NSLOT; s++) begin : g_hit
    assign hit[s] = valid[s] & flags[sel[s]];
  end

  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int s = NSLOT - 1; s >= 0; s--) begin
      if (hit[s]) begin
        any = 1'b1;
        idx = IDX_W'(s);
      end
    end
  end
endmodule

// File: rtl/multiway_branch_resolver.sv
module multiway_branch_resolver
  import mwbr_pkg::*;
#(
  parameter int unsigned NSLOT   = 4,
  parameter int unsigned NFLAG   = 8,
  parameter int unsigned NCMP    = 2,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned PC_W    = 16,
  parameter int unsigned PC_STEP = PC_STEP_DEF
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic [NCMP-1:0]                      cmp_en,
  input  logic [NCMP-1:0][DATA_W-1:0]          cmp_a,
  input  logic [NCMP-1:0][DATA_W-1:0]          cmp_b,
  input  logic [NCMP-1:0][$clog2(NFLAG)-1:0]   cmp_dst,
  input  logic [NSLOT-1:0]                     br_valid,
  input  logic [NSLOT-1:0][$clog2(NFLAG)-1:0]  br_sel,
  input  logic [NSLOT-1:0][PC_W-1:0]           br_target,
  input  logic [PC_W-1:0]                      cur_pc,
  output logic [PC_W-1:0]                      next_pc,
  output logic [$clog2(NSLOT)-1:0]             win_slot,
  output logic                                 taken
);
  localparam int unsigned FSEL_W = $clog2(NFLAG);
  localparam int unsigned IDX_W  = $clog2(NSLOT);

  logic [NCMP-1:0]  cmp_eq;
  logic [NFLAG-1:0] flag_q;
  logic             pick_any;
  logic [IDX_W-1:0] pick_idx;
  flow_e            flow;
  logic [PC_W-1:0]  pc_d;

  mwbr_cmp_unit #(.NCMP(NCMP), .DATA_W(DATA_W)) u_cmp (
    .op_a  (cmp_a),
    .op_b  (cmp_b),
    .equal (cmp_eq)
  );

  mwbr_flag_bank #(.NCMP(NCMP), .NFLAG(NFLAG)) u_bank (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (cmp_en),
    .wr_dst (cmp_dst),
    .wr_val (cmp_eq),
    .flags  (flag_q)
  );

  mwbr_prio_pick #(.NSLOT(NSLOT), .NFLAG(NFLAG)) u_pick (
    .flags (flag_q),
    .valid (br_valid),
    .sel   (br_sel),
    .any   (pick_any),
    .idx   (pick_idx)
  );

  always_comb begin
    flow = pick_any ? FLOW_JUMP : FLOW_STEP;
    pc_d = (flow == FLOW_JUMP) ? br_target[pick_idx] : cur_pc + PC_W'(PC_STEP);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      next_pc  <= '0;
      win_slot <= '0;
      taken    <= 1'b0;
    end else begin
      next_pc  <= pc_d;
      win_slot <= pick_idx;
      taken    <= (flow == FLOW_JUMP);
    end
  end

  // R5
  slot0_first_chk: assert property (@(posedge clk) disable iff (rst)
    (br_valid[0] && flag_q[br_sel[0]]) |=> (taken && win_slot == '0 && next_pc == $past(br_target[0])));

  // R7
  step_pc_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !taken) |-> (next_pc == $past(cur_pc) + PC_W'(PC_STEP) && win_slot == '0));

  // R4
  none_hit_chk: assert property (@(posedge clk) disable iff (rst)
    ((br_valid & {NSLOT{1'b1}}) == '0) |=> !taken);

  // R6
  for (genvar s = 0; s < NSLOT; s++) begin : g_inv_chk
    invalid_slot_chk: assert property (@(posedge clk) disable iff (rst)
      !br_valid[s] |=> !(taken && win_slot == IDX_W'(s)));
  end
endmodule

// File: tb/multiway_branch_resolver_test.sv
module multiway_branch_resolver_test;
  localparam int NSLOT = 4, NFLAG = 8, NCMP = 2, DW = 8, PCW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NCMP-1:0]             cmp_en = '0;
  logic [NCMP-1:0][DW-1:0]     cmp_a = '0, cmp_b = '0;
  logic [NCMP-1:0][2:0]        cmp_dst = '0;
  logic [NSLOT-1:0]            br_valid = '0;
  logic [NSLOT-1:0][2:0]       br_sel = '0;
  logic [NSLOT-1:0][PCW-1:0]   br_target = '0;
  logic [PCW-1:0]              cur_pc = '0;
  logic [PCW-1:0]              next_pc;
  logic [1:0]                  win_slot;
  logic                        taken;

  int n_chk = 0, n_fail = 0;
  logic [NFLAG-1:0] model = '0;
  bit done = 0;

  always #10 clk = ~clk;

  multiway_branch_resolver uut (
    .clk(clk), .rst(rst), .cmp_en(cmp_en), .cmp_a(cmp_a), .cmp_b(cmp_b),
    .cmp_dst(cmp_dst), .br_valid(br_valid), .br_sel(br_sel),
    .br_target(br_target), .cur_pc(cur_pc), .next_pc(next_pc),
    .win_slot(win_slot), .taken(taken)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, logic [PCW+2:0] act, logic [PCW+2:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_lane(int c, int dst, bit eq, int seed);
    cmp_dst[c] = 3'(dst);
    cmp_a[c]   = 8'(seed);
    cmp_b[c]   = eq ? 8'(seed) : (8'(seed) ^ 8'h5A);
  endtask

  // computes the expected outputs from the model of the registers
  task automatic check_branch(string req);
    int win;
    logic [PCW-1:0] epc;
    win = -1;
    for (int s = NSLOT - 1; s >= 0; s--)
      if (br_valid[s] && model[br_sel[s]]) win = s;
    epc = (win < 0) ? cur_pc + 16'd1 : br_target[win];
    tick();
    chk(req, {taken, win_slot, next_pc}, {(win >= 0), 2'((win < 0) ? 0 : win), epc});
  endtask

  initial begin
    repeat (3) tick();
    // R8 reset state
    chk("R8", {taken, win_slot, next_pc}, '0);
    rst = 1'b0;

    // R1 R2: load every pattern through compares, read back via branches
    for (int p = 0; p < 256; p++) begin
      for (int k = 0; k < 4; k++) begin
        cmp_en = 2'b11;
        set_lane(0, 2*k,   p[2*k],   p + k);
        set_lane(1, 2*k+1, p[2*k+1], p * 7 + k);
        br_valid = '0;
        cur_pc = 16'(p);
        tick();
        model[2*k]   = p[2*k];
        model[2*k+1] = p[2*k+1];
      end
      cmp_en = '0;
      for (int cfg = 0; cfg < 3; cfg++) begin
        for (int s = 0; s < NSLOT; s++) begin
          br_sel[s]    = (cfg == 2) ? 3'd3 : 3'((2*s + cfg) % 8);
          br_target[s] = 16'h1000 + 16'(s * 16'h111) + 16'(cfg);
        end
        for (int v = 0; v < 16; v++) begin
          br_valid = 4'(v);
          cur_pc = 16'(p * 3 + v);
          // R4 R5 R6 R7 R2 (held since load) R1 (values written)
          check_branch("R5");
        end
      end
    end

    // R3: both lanes to register 5, lane 1 says equal, lane 0 not
    cmp_en = 2'b11; br_valid = '0;
    set_lane(0, 5, 1'b0, 9); set_lane(1, 5, 1'b1, 11);
    tick(); model[5] = 1'b1;
    cmp_en = '0; br_valid = 4'b0001; br_sel[0] = 3'd5; br_target[0] = 16'hBEEF;
    check_branch("R3");
    cmp_en = 2'b11; br_valid = '0;
    set_lane(0, 5, 1'b1, 9); set_lane(1, 5, 1'b0, 11);
    tick(); model[5] = 1'b0;
    cmp_en = '0; br_valid = 4'b0001;
    check_branch("R3");

    // R4: same-cycle compare does not affect branch (reads old value 0)
    cmp_en = 2'b01; set_lane(0, 5, 1'b1, 3);
    br_valid = 4'b0001; br_sel[0] = 3'd5; cur_pc = 16'h0040;
    check_branch("R4");
    model[5] = 1'b1; cmp_en = '0;
    check_branch("R4");

    // R6: invalid slot with set bit, R7 wrap
    br_valid = 4'b0000; cur_pc = 16'hFFFF;
    check_branch("R6");
    chk("R7", {1'b0, 2'b00, next_pc}, {1'b0, 2'b00, 16'h0000});

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule